// File: doc/BRIEF.md
# Cascadable Eight-Line Interrupt Controller

This block takes eight interrupt request lines and a byte-wide register port with a one-bit address. A static strap sets whether the unit is the master or a slave of a two-level cascade. Software first writes a short initialization sequence of two to four words. One of those words is the cascade configuration byte. In a master this byte is a map of the inputs that have slaves attached. In a slave it is a 3-bit identity: the number of the master input that the slave drives.

Once initialized, the unit keeps a mask register and a request register. A request on a line whose mask bit is clear is latched into the request register, and a summary interrupt output shows whether any unmasked request is pending. A slave also pulses a cascade request output and presents its identity, so that the surrounding logic can raise the matching master input. A master treats each bit of its cascade input as a request on the line of the same number. A request on a line number above 7 is flagged on an error output and otherwise ignored. Priority resolution, acknowledge cycles and end-of-interrupt handling belong to other blocks.

Top module: `cascade_pic`

## Requirements
- R1: After reset the mask, request and cascade bytes read as 0x00, `int_out`, `casc_req` and `irq_err` are low, and a write to address 1 changes nothing until initialization has completed.
- R2: A write to address 0 with data bit 4 set starts initialization at word 1, from any state, and clears the request and mask registers. Bit 1 of word 1 set means no cascade. Bit 0 set means a word 4 follows.
- R3: After word 2 (the next address-1 write), the sequence waits for word 3 only when bit 1 of word 1 was 0. Otherwise the cascade byte is cleared and word 3 is skipped.
- R4: In a master, word 3 is stored as the whole 8-bit cascade byte.
- R5: In a slave, only bits [2:0] of word 3 are kept, the upper five bits of the cascade byte read 0, and `casc_id` shows the kept value.
- R6: The sequence takes word 4 only when bit 0 of word 1 was 1, and then completes. Once initialization is complete, address-1 writes load the mask and address-1 reads return it. The word-4 write does not load the mask.
- R7: Raising a line number above 7 pulses `irq_err` high for one cycle, one clock edge later, and leaves the request register and `casc_req` unchanged.
- R8: Raising a line whose mask bit is 1 sets no request bit and produces no `casc_req`.
- R9: Raising an unmasked line n sets request bit n at the next clock edge. Request bits stay set until the next word 1. `int_out` is high exactly while some request bit is set and its mask bit is clear.
- R10: A slave answers an unmasked raise in range with a one-cycle `casc_req` pulse at the next edge, while `casc_id` holds its identity. A master never asserts `casc_req`.
- R11: In a master, `casc_in[n]` high for a cycle acts as a raise of line n, subject to the mask. A slave ignores `casc_in`.
- R12: A write to address 0 with bit 4 clear and bit 3 set sets the read select to data bit 0. An address-0 read returns the request register when the select is 0 and the cascade byte when it is 1. After reset the select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| role_is_master | input | 1 | Strap: 1 for master, 0 for slave |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_raise | input | 1 | One-cycle request on the line given by `irq_line` |
| irq_line | input | 4 | Line number of the request (0 to 7 valid) |
| casc_in | input | 8 | Master only: requests forwarded by slaves, one bit per input |
| irq_err | output | 1 | One-cycle pulse when a line above 7 was raised |
| casc_req | output | 1 | Slave only: one-cycle forwarded request pulse |
| casc_id | output | 3 | Slave identity: the master input to raise |
| int_out | output | 1 | High while any unmasked request bit is set |

## Verification
Every stored result (request bits, mask, cascade byte, sequence state, the `irq_err` and `casc_req` pulses) appears one rising edge after the stimulus cycle. `int_out` and `bus_rdata` are combinational views of that state. The bench drives each stimulus for one full cycle from a falling edge. It samples at the next falling edge, after the single register stage, and checks that the pulses are low again one cycle later. Reads set `bus_addr` and sample after a short settling delay, with no write in flight.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NLINES = 8;

  // Word-1 and command bit positions decoded by the sequencer
  localparam int W1_START = 4;
  localparam int W1_SOLO  = 1;
  localparam int W1_WANT4 = 0;
  localparam int CMD_RSEL = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W2,
    ST_W3,
    ST_W4,
    ST_RUN
  } init_st_t;
endpackage

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
  import pic_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ID_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              role_is_master,
  input  logic              ctl_we,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              run,
  output logic              restart,
  output logic              rsel,
  output logic [DATA_W-1:0] cfg
);
  localparam logic [DATA_W-1:0] ID_KEEP = {{(DATA_W-ID_W){1'b0}}, {ID_W{1'b1}}};

  init_st_t          st_q, st_d;
  logic              solo_q, solo_d;
  logic              want4_q, want4_d;
  logic              rsel_q, rsel_d;
  logic [DATA_W-1:0] cfg_q, cfg_d;

  always_comb begin
    st_d    = st_q;
    solo_d  = solo_q;
    want4_d = want4_q;
    rsel_d  = rsel_q;
    cfg_d   = cfg_q;
    restart = ctl_we && wdata[W1_START];
    if (restart) begin
      st_d    = ST_W2;
      solo_d  = wdata[W1_SOLO];
      want4_d = wdata[W1_WANT4];
    end else if (ctl_we && wdata[CMD_RSEL]) begin
      rsel_d = wdata[0];
    end else if (dat_we) begin
      case (st_q)
        ST_W2: begin
          if (!solo_q) begin
            st_d = ST_W3;
          end else begin
            cfg_d = '0;
            st_d  = want4_q ? ST_W4 : ST_RUN;
          end
        end
        ST_W3: begin
          cfg_d = role_is_master ? wdata : (wdata & ID_KEEP);
          st_d  = want4_q ? ST_W4 : ST_RUN;
        end
        ST_W4:   st_d = ST_RUN;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      solo_q  <= 1'b0;
      want4_q <= 1'b0;
      rsel_q  <= 1'b0;
      cfg_q   <= '0;
    end else begin
      st_q    <= st_d;
      solo_q  <= solo_d;
      want4_q <= want4_d;
      rsel_q  <= rsel_d;
      cfg_q   <= cfg_d;
    end
  end

  assign run  = (st_q == ST_RUN);
  assign rsel = rsel_q;
  assign cfg  = cfg_q;
endmodule

// File: rtl/pic_req_unit.sv
module pic_req_unit
  import pic_pkg::*;
#(
  parameter int LINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              role_is_master,
  input  logic              clr,
  input  logic              mask_we,
  input  logic [NLINES-1:0] mask_wdata,
  input  logic              raise,
  input  logic [LINE_W-1:0] line,
  input  logic [NLINES-1:0] casc_in,
  output logic [NLINES-1:0] req,
  output logic [NLINES-1:0] mask,
  output logic              err,
  output logic              fwd,
  output logic              int_out
);
  logic [NLINES-1:0] req_q, req_d;
  logic [NLINES-1:0] mask_q, mask_d;
  logic              err_q, err_d;
  logic              fwd_q, fwd_d;
  logic [NLINES-1:0] local_hit;
  logic [NLINES-1:0] all_hit;

  for (genvar i = 0; i < NLINES; i++) begin : g_hit
    assign local_hit[i] = raise && (line == LINE_W'(i));
    assign all_hit[i]   = local_hit[i] || (role_is_master && casc_in[i]);
  end

  always_comb begin
    req_d  = clr ? '0 : (req_q | (all_hit & ~mask_q));
    mask_d = clr ? '0 : (mask_we ? mask_wdata : mask_q);
    err_d  = raise && (line >= LINE_W'(NLINES));
    fwd_d  = !role_is_master && |(local_hit & ~mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      mask_q <= '0;
      err_q  <= 1'b0;
      fwd_q  <= 1'b0;
    end else begin
      req_q  <= req_d;
      mask_q <= mask_d;
      err_q  <= err_d;
      fwd_q  <= fwd_d;
    end
  end

  assign req     = req_q;
  assign mask    = mask_q;
  assign err     = err_q;
  assign fwd     = fwd_q;
  assign int_out = |(req_q & ~mask_q);
endmodule

// File: rtl/cascade_pic.sv
module cascade_pic
  import pic_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LINE_W     = 4,
  parameter int ID_W       = 3,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              role_is_master,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_raise,
  input  logic [LINE_W-1:0] irq_line,
  input  logic [NLINES-1:0] casc_in,
  output logic              irq_err,
  output logic              casc_req,
  output logic [ID_W-1:0]   casc_id,
  output logic              int_out
);
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_core_n;
  logic                  ctl_we, dat_we, mask_we;
  logic                  run, restart, rsel;
  logic [DATA_W-1:0]     cfg_q;
  logic [NLINES-1:0]     req_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[RST_STAGES-1];

  assign ctl_we  = bus_we && !bus_addr;
  assign dat_we  = bus_we && bus_addr;
  assign mask_we = dat_we && run;

  pic_init_fsm #(.DATA_W(DATA_W), .ID_W(ID_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_core_n),
    .role_is_master (role_is_master),
    .ctl_we         (ctl_we),
    .dat_we         (dat_we),
    .wdata          (bus_wdata),
    .run            (run),
    .restart        (restart),
    .rsel           (rsel),
    .cfg            (cfg_q)
  );

  pic_req_unit #(.LINE_W(LINE_W)) u_req (
    .clk            (clk),
    .rst_n          (rst_core_n),
    .role_is_master (role_is_master),
    .clr            (restart),
    .mask_we        (mask_we),
    .mask_wdata     (bus_wdata[NLINES-1:0]),
    .raise          (irq_raise),
    .line           (irq_line),
    .casc_in        (casc_in),
    .req            (req_q),
    .mask           (mask_q),
    .err            (irq_err),
    .fwd            (casc_req),
    .int_out        (int_out)
  );

  assign casc_id   = role_is_master ? '0 : cfg_q[ID_W-1:0];
  assign bus_rdata = bus_addr ? DATA_W'(mask_q) : (rsel ? cfg_q : DATA_W'(req_q));
endmodule

// File: rtl/pic_chk.sv
module pic_chk (
  input logic       clk,
  input logic       rst_core_n,
  input logic       role_is_master,
  input logic       bus_we,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic       irq_raise,
  input logic [3:0] irq_line,
  input logic [7:0] casc_in,
  input logic       irq_err,
  input logic       casc_req,
  input logic       int_out,
  input logic [7:0] req_q,
  input logic [7:0] mask_q,
  input logic [7:0] cfg_q
);
  AST_BAD_LINE_FLAG: assert property (@(posedge clk) disable iff (!rst_core_n)
    (irq_raise && irq_line > 4'd7) |=> irq_err); // R7
  AST_BAD_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_core_n)
    (irq_raise && irq_line > 4'd7 && !bus_we && (casc_in == 8'h00 || !role_is_master))
      |=> (req_q == $past(req_q) && !casc_req)); // R7
  AST_MASTER_NO_FWD: assert property (@(posedge clk) disable iff (!rst_core_n)
    role_is_master |-> !casc_req); // R10
  AST_MASKED_DROP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!role_is_master && irq_raise && irq_line < 4'd8 && mask_q[irq_line[2:0]])
      |=> !casc_req); // R8
  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(bus_we && !bus_addr && bus_wdata[4])
      |=> ((req_q & $past(req_q)) == $past(req_q))); // R9
  AST_SLAVE_ID_NARROW: assert property (@(posedge clk) disable iff (!rst_core_n)
    !role_is_master |-> (cfg_q[7:3] == 5'd0)); // R5
  AST_INT_CAUSE: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(int_out) |-> $past(irq_raise || (|casc_in) || bus_we)); // R9
endmodule

bind cascade_pic pic_chk u_chk (
  .clk            (clk),
  .rst_core_n     (rst_core_n),
  .role_is_master (role_is_master),
  .bus_we         (bus_we),
  .bus_addr       (bus_addr),
  .bus_wdata      (bus_wdata),
  .irq_raise      (irq_raise),
  .irq_line       (irq_line),
  .casc_in        (casc_in),
  .irq_err        (irq_err),
  .casc_req       (casc_req),
  .int_out        (int_out),
  .req_q          (req_q),
  .mask_q         (mask_q),
  .cfg_q          (cfg_q)
);

// File: tb/cascade_pic_bench.sv
module cascade_pic_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       role_is_master = 1'b1;
  logic       bus_we = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_raise = 1'b0;
  logic [3:0] irq_line = 4'd0;
  logic [7:0] casc_in = 8'h00;
  logic       irq_err, casc_req, int_out;
  logic [2:0] casc_id;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_req, m_mask;

  always #2 clk = ~clk;

  cascade_pic u_cascade_pic (
    .clk(clk), .rst_n(rst_n), .role_is_master(role_is_master),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_raise(irq_raise), .irq_line(irq_line), .casc_in(casc_in),
    .irq_err(irq_err), .casc_req(casc_req), .casc_id(casc_id), .int_out(int_out)
  );

  function automatic logic [7:0] next_req(logic [7:0] req, logic [7:0] msk,
                                          logic [3:0] ln, logic [7:0] ci, logic master);
    logic [7:0] hit;
    hit = master ? ci : 8'h00;
    if (ln < 4'd8) hit[ln[2:0]] = 1'b1;
    return req | (hit & ~msk);
  endfunction

  function automatic logic exp_fwd(logic [7:0] msk, logic [3:0] ln, logic master);
    return !master && ln < 4'd8 && !msk[ln[2:0]];
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    bus_addr = a;
    #0.5;
    v = bus_rdata;
  endtask

  task automatic raise(logic r, logic [3:0] ln, logic [7:0] ci);
    @(negedge clk);
    irq_raise = r; irq_line = ln; casc_in = ci;
    @(negedge clk);
    irq_raise = 1'b0; casc_in = 8'h00;
  endtask

  task automatic do_reset(logic master);
    @(negedge clk);
    rst_n = 1'b0;
    role_is_master = master;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_req = 8'h00; m_mask = 8'h00;
  endtask

  task automatic check_state(string tag);
    logic [7:0] v;
    rd(1'b1, v); check({tag, " mask"}, v, m_mask);
    rd(1'b0, v); check({tag, " req"}, v, m_req);
    check({tag, " int_out"}, {7'd0, int_out}, {7'd0, |(m_req & ~m_mask)});
  endtask

  task automatic random_phase(logic master, int n);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      if ($urandom % 5 == 0) begin
        v = 8'($urandom);
        wr(1'b1, v); m_mask = v;
        check_state("R6 random mask write");
      end else begin
        logic [3:0] ln;
        logic [7:0] ci;
        logic       ef;
        ln = 4'($urandom % 10);
        ci = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
        ef = exp_fwd(m_mask, ln, master);
        raise(1'b1, ln, ci);
        m_req = next_req(m_req, m_mask, ln, ci, master);
        check("R7 irq_err", {7'd0, irq_err}, {7'd0, ln > 4'd7});
        check("R10 casc_req", {7'd0, casc_req}, {7'd0, ef});
        check_state("R9 R11 random raise");
      end
    end
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    m_req = 8'h00; m_mask = 8'h00;

    // Master, reset state
    do_reset(1'b1);
    check_state("R1 reset");
    check("R1 casc_req", {7'd0, casc_req}, 8'h00);
    check("R1 irq_err", {7'd0, irq_err}, 8'h00);
    wr(1'b1, 8'hFF);
    check_state("R1 mask write before init ignored");

    // Master: cascade, word 4 expected
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h20);
    wr(1'b1, 8'hA5);
    rd(1'b1, v); check("R6 no mask during word3", v, 8'h00);
    wr(1'b1, 8'h3C);
    rd(1'b1, v); check("R6 word4 not a mask", v, 8'h00);
    wr(1'b0, 8'h09);
    rd(1'b0, v); check("R4 R12 cascade byte", v, 8'hA5);
    check("R5 master casc_id", {5'd0, casc_id}, 8'h00);
    wr(1'b0, 8'h08);
    wr(1'b1, 8'h0F); m_mask = 8'h0F;
    check_state("R6 mask load");

    // Directed: masked line, unmasked line, bad line, cascade input
    raise(1'b1, 4'd2, 8'h00);
    check("R8 masked no error", {7'd0, irq_err}, 8'h00);
    check_state("R8 masked dropped");
    raise(1'b1, 4'd7, 8'h00); m_req = 8'h80;
    check("R10 master no casc_req", {7'd0, casc_req}, 8'h00);
    check_state("R9 line 7 latched");
    raise(1'b1, 4'd8, 8'h00);
    check("R7 line 8 flagged", {7'd0, irq_err}, 8'h01);
    check_state("R7 line 8 no effect");
    @(negedge clk);
    check("R7 error one cycle", {7'd0, irq_err}, 8'h00);
    raise(1'b0, 4'd0, 8'h21); m_req = 8'hA0;
    check_state("R11 master cascade input");
    wr(1'b1, 8'hA0); m_mask = 8'hA0;
    check_state("R9 masking pending drops int_out");
    wr(1'b1, 8'h00); m_mask = 8'h00;
    random_phase(1'b1, 40);

    // Restart: solo with word 4
    wr(1'b0, 8'h13); m_req = 8'h00; m_mask = 8'h00;
    check_state("R2 word1 clears");
    wr(1'b1, 8'h55);
    wr(1'b1, 8'h77);
    rd(1'b1, v); check("R3 R6 word4 after skip", v, 8'h00);
    wr(1'b0, 8'h09);
    rd(1'b0, v); check("R3 solo clears cascade byte", v, 8'h00);
    wr(1'b0, 8'h08);
    // Solo, no word 4: complete after word 2
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h40);
    wr(1'b1, 8'h81); m_mask = 8'h81;
    check_state("R3 R6 ready after word2");

    // Slave
    do_reset(1'b0);
    check_state("R1 slave reset");
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'hFE);
    wr(1'b0, 8'h09);
    rd(1'b0, v); check("R5 slave id kept", v, 8'h06);
    check("R5 casc_id", {5'd0, casc_id}, 8'h06);
    wr(1'b0, 8'h08);
    wr(1'b1, 8'h04); m_mask = 8'h04;
    check_state("R6 no word4 ready");
    raise(1'b1, 4'd3, 8'h00); m_req = 8'h08;
    check("R10 slave forwards", {7'd0, casc_req}, 8'h01);
    check("R10 casc_id during pulse", {5'd0, casc_id}, 8'h06);
    check_state("R9 slave latch");
    @(negedge clk);
    check("R10 pulse one cycle", {7'd0, casc_req}, 8'h00);
    raise(1'b1, 4'd2, 8'h00);
    check("R8 masked no forward", {7'd0, casc_req}, 8'h00);
    check_state("R8 slave masked");
    raise(1'b0, 4'd0, 8'hFF);
    check_state("R11 slave ignores casc_in");
    raise(1'b1, 4'd15, 8'h00);
    check("R7 slave line 15", {7'd0, irq_err}, 8'h01);
    check("R7 no forward", {7'd0, casc_req}, 8'h00);
    check_state("R7 slave no effect");
    random_phase(1'b0, 40);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule